// File: doc/BRIEF.md
# PIO Multi-Sector Transfer Sequencer

This block is the device-side sequencer for programmed-I/O data commands on a disk-style task-file interface. Once an external register decoder hands it a command code together with the sector count and the current block size, it steps the busy flag, the data-request flag and an interrupt-pending flag through the data-in or data-out handshake. A media stub tells it when a block is ready (reads) or has been processed (writes). The host moves data one 16-bit word per strobe. An external buffer holds the words, and this block only counts them.

Commands can run one sector per interrupt or in block mode. In block mode each data request and each interrupt covers a programmed number of sectors, and the final block is shortened to whatever remains. Errors end the command with the count of sectors still outstanding. A block-mode command that arrives while no block size is programmed is refused. A new command always abandons the one in progress.

Data moves as a stream. `dat_valid` is the host word strobe and `drq` acts as its ready: a word is accepted only in a cycle with both high. A strobe while `drq` is low is dropped and never counted. The host controls the pace, so any number of idle cycles may separate words.

Top module: `pio_xfer_seq`

## Requirements
- R1: After reset, `bsy`, `drq`, `irq_pend`, `err` and `abrt` are 0 and `sect_left` is 0.
- R2: Read sectors (code 8'h20). The cycle after the command, `bsy`=1 and `drq`=0. On `media_rdy` the sequencer sets `drq`=1, clears `bsy` and sets `irq_pend`. When the last word of the sector is accepted, `drq` falls and `sect_left` decrements. It then returns to `bsy`=1 if sectors remain, or goes idle if none do.
- R3: Write sectors (code 8'h30). The cycle after the command, `drq`=1 and `bsy`=0, with no interrupt. After the sector's last word, `bsy`=1 and `drq`=0. On `media_rdy`, `sect_left` decrements, `bsy` clears and `irq_pend` sets. `drq` also returns to 1 if sectors remain.
- R4: Read multiple (8'hC4) and write multiple (8'hC5) use blocks of `mult_size` sectors. `drq` stays high and no new interrupt occurs across the whole block. The last block holds only the remaining sectors.
- R5: A multiple command issued while `mult_size`=0, or any other unknown code, ends at once with `abrt`=1, `err`=1, `irq_pend`=1, `bsy`=`drq`=0, and `sect_left` equal to the requested count.
- R6: On a read, `media_rdy` with `err_unc`=1 still raises `drq` and transfers that block, with `err`=1. After that block the command ends, and `sect_left` holds the sectors not yet transferred.
- R7: On a write, `media_rdy` with `err_wr`=1 ends the command with `err`=1 and `irq_pend`=1. The failing block is not subtracted from `sect_left`, and `drq` does not rise again.
- R8: A sector count input of 0 means 256 sectors, so `sect_left` reads 256.
- R9: `irq_pend` is cleared by `status_rd` or by a command. If an interrupt-raising event falls in the same cycle as `status_rd`, the event wins and `irq_pend` reads 1.
- R10: A command that arrives while another is in progress restarts the sequencer. No status or interrupt is reported for the old command.
- R11: `dat_valid` pulses while `drq`=0 have no effect on the word count of the next block.
- R12: A sector is WORDS accepted words, so a block completes on exactly `blk_len`×WORDS strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command register write |
| cmd_code | input | 8 | Command code |
| sect_cnt_in | input | SC_W | Sector count, 0 means 256 |
| mult_size | input | SC_W | Programmed block size, 0 means block mode disabled |
| dat_valid | input | 1 | Host word strobe (accepted when `drq`=1) |
| media_rdy | input | 1 | Media stub: block ready (read) or processed (write) |
| err_unc | input | 1 | Uncorrectable read error, qualified by `media_rdy` |
| err_wr | input | 1 | Write failure, qualified by `media_rdy` |
| status_rd | input | 1 | Host read of the status register |
| bsy | output | 1 | Busy flag |
| drq | output | 1 | Data request, ready for `dat_valid` |
| irq_pend | output | 1 | Interrupt pending |
| err | output | 1 | Error status bit |
| abrt | output | 1 | Aborted-command error bit |
| sect_left | output | SC_W+1 | Sectors outstanding |

## Verification
The interrupt latch can be set by a block becoming ready and cleared by a status read in the same cycle. The bench provokes this by pulsing `media_rdy` and `status_rd` together during a read. It judges that `irq_pend` reads 1 afterwards while `drq` rises. A command strobe that lands mid-transfer is the second collision, since it both clears the latch and restarts the sequence. The bench checks it by interrupting a 256-sector read with a write and then completing the write normally.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MEDIA, ST_XFER} seq_state_e;
  localparam logic [7:0] OP_RD  = 8'h20;
  localparam logic [7:0] OP_WR  = 8'h30;
  localparam logic [7:0] OP_RDM = 8'hC4;
  localparam logic [7:0] OP_WRM = 8'hC5;
endpackage

// File: rtl/pio_blk_ctr.sv
module pio_blk_ctr #(
  parameter int WORDS = 256,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          acc,
  input  logic [CW-1:0] blk_len,
  output logic          blk_done
);
  localparam int WW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [WW-1:0] widx;
  logic [CW-1:0] sidx;
  logic          last_w, last_s;

  assign last_w   = (widx == WW'(WORDS - 1));
  assign last_s   = (sidx == blk_len - CW'(1));
  assign blk_done = acc && last_w && last_s;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      widx <= '0;
      sidx <= '0;
    end else if (acc) begin
      if (last_w) begin
        widx <= '0;
        sidx <= last_s ? '0 : sidx + CW'(1);
      end else begin
        widx <= widx + WW'(1);
      end
    end
  end
endmodule

// File: rtl/pio_irq_latch.sv
module pio_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/pio_xfer_seq.sv
module pio_xfer_seq #(
  parameter int SC_W  = 8,
  parameter int WORDS = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_code,
  input  logic [SC_W-1:0] sect_cnt_in,
  input  logic [SC_W-1:0] mult_size,
  input  logic            dat_valid,
  input  logic            media_rdy,
  input  logic            err_unc,
  input  logic            err_wr,
  input  logic            status_rd,
  output logic            bsy,
  output logic            drq,
  output logic            irq_pend,
  output logic            err,
  output logic            abrt,
  output logic [SC_W:0]   sect_left
);
  import pio_seq_pkg::*;
  localparam int CW = SC_W + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << SC_W;

  seq_state_e      state;
  logic            dir_wr, multi, stop;
  logic [SC_W-1:0] ms_q;
  logic [CW-1:0]   blk_len, cmd_cnt, remain;
  logic            known, is_multi, is_write, rejected;
  logic            word_acc, blk_done, irq_set;

  function automatic logic [CW-1:0] blen(input logic [CW-1:0] left,
                                         input logic mul,
                                         input logic [SC_W-1:0] ms);
    if (!mul)                  return CW'(1);
    else if (left < {1'b0, ms}) return left;
    else                        return {1'b0, ms};
  endfunction

  always_comb begin
    known    = (cmd_code == OP_RD) || (cmd_code == OP_WR) ||
               (cmd_code == OP_RDM) || (cmd_code == OP_WRM);
    is_multi = (cmd_code == OP_RDM) || (cmd_code == OP_WRM);
    is_write = (cmd_code == OP_WR) || (cmd_code == OP_WRM);
    rejected = !known || (is_multi && (mult_size == '0));
    cmd_cnt  = (sect_cnt_in == '0) ? FULL : {1'b0, sect_cnt_in};
    remain   = sect_left - blk_len;
  end

  assign bsy      = (state == ST_MEDIA);
  assign drq      = (state == ST_XFER);
  assign word_acc = dat_valid && drq && !cmd_valid;
  assign irq_set  = cmd_valid ? rejected : (bsy && media_rdy);

  pio_blk_ctr #(.WORDS(WORDS), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(cmd_valid), .acc(word_acc),
    .blk_len(blk_len), .blk_done(blk_done)
  );

  pio_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set),
    .clr(status_rd || cmd_valid), .q(irq_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dir_wr    <= 1'b0;
      multi     <= 1'b0;
      stop      <= 1'b0;
      ms_q      <= '0;
      blk_len   <= CW'(1);
      sect_left <= '0;
      err       <= 1'b0;
      abrt      <= 1'b0;
    end else if (cmd_valid) begin
      stop      <= 1'b0;
      sect_left <= cmd_cnt;
      dir_wr    <= is_write;
      multi     <= is_multi;
      ms_q      <= mult_size;
      err       <= rejected;
      abrt      <= rejected;
      blk_len   <= blen(cmd_cnt, is_multi, mult_size);
      if (rejected)      state <= ST_IDLE;
      else if (is_write) state <= ST_XFER;
      else               state <= ST_MEDIA;
    end else begin
      case (state)
        ST_MEDIA: if (media_rdy) begin
          if (!dir_wr) begin
            blk_len <= blen(sect_left, multi, ms_q);
            state   <= ST_XFER;
            if (err_unc) begin
              err  <= 1'b1;
              stop <= 1'b1;
            end
          end else if (err_wr) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            sect_left <= remain;
            if (remain == '0) state <= ST_IDLE;
            else begin
              blk_len <= blen(remain, multi, ms_q);
              state   <= ST_XFER;
            end
          end
        end
        ST_XFER: if (blk_done) begin
          if (!dir_wr) begin
            sect_left <= remain;
            state     <= ((remain == '0) || stop) ? ST_IDLE : ST_MEDIA;
          end else begin
            state <= ST_MEDIA;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pio_xfer_seq_chk.sv
module pio_xfer_seq_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_code,
  input logic          dat_valid,
  input logic          media_rdy,
  input logic          status_rd,
  input logic          bsy,
  input logic          drq,
  input logic          irq_pend,
  input logic [CW-1:0] sect_left
);
  // R2
  bsy_drq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsy && drq));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !cmd_valid && !(bsy && media_rdy)) |=> !irq_pend);

  // R3
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(media_rdy || cmd_valid));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sect_left <= (CW'(1) << (CW - 1)));

  // R11
  drq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drq) |-> $past(dat_valid || cmd_valid));

  // R3
  wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 8'h30) |=> (drq && !irq_pend));
endmodule

bind pio_xfer_seq pio_xfer_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .dat_valid(dat_valid), .media_rdy(media_rdy), .status_rd(status_rd),
  .bsy(bsy), .drq(drq), .irq_pend(irq_pend), .sect_left(sect_left)
);

// File: tb/pio_xfer_seq_bench.sv
module pio_xfer_seq_bench;
  localparam int SC_W  = 8;
  localparam int WORDS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, dat_valid = 0, media_rdy = 0, err_unc = 0, err_wr = 0, status_rd = 0;
  logic [7:0] cmd_code = '0;
  logic [SC_W-1:0] sect_cnt_in = '0, mult_size = '0;
  logic bsy, drq, irq_pend, err, abrt;
  logic [SC_W:0] sect_left;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string tag;
    logic b, d, i, e, a;
    logic [SC_W:0] left;
  } exp_t;
  exp_t exp_q[$];
  event snap;

  always #5 clk = ~clk;

  pio_xfer_seq #(.SC_W(SC_W), .WORDS(WORDS)) u_pio_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sect_cnt_in(sect_cnt_in), .mult_size(mult_size), .dat_valid(dat_valid),
    .media_rdy(media_rdy), .err_unc(err_unc), .err_wr(err_wr),
    .status_rd(status_rd), .bsy(bsy), .drq(drq), .irq_pend(irq_pend),
    .err(err), .abrt(abrt), .sect_left(sect_left)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(snap);
      while (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        checks++;
        if ({bsy, drq, irq_pend, err, abrt} !== {x.b, x.d, x.i, x.e, x.a} ||
            sect_left !== x.left) begin
          fails++;
          $display("FAIL %s: got bsy=%b drq=%b irq=%b err=%b abrt=%b left=%0d, expected bsy=%b drq=%b irq=%b err=%b abrt=%b left=%0d",
                   x.tag, bsy, drq, irq_pend, err, abrt, sect_left,
                   x.b, x.d, x.i, x.e, x.a, x.left);
        end
      end
    end
  end

  task automatic expect_st(input string tag, input logic b, input logic d,
                           input logic i, input logic e, input logic a,
                           input int left);
    exp_t x;
    x.tag = tag; x.b = b; x.d = d; x.i = i; x.e = e; x.a = a;
    x.left = (SC_W+1)'(left);
    exp_q.push_back(x);
    -> snap;
    #1;
  endtask

  task automatic issue(input logic [7:0] code, input int cnt, input int ms);
    @(negedge clk);
    cmd_valid = 1; cmd_code = code;
    sect_cnt_in = SC_W'(cnt); mult_size = SC_W'(ms);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic media(input logic unc, input logic wr, input logic srd);
    @(negedge clk);
    media_rdy = 1; err_unc = unc; err_wr = wr; status_rd = srd;
    @(negedge clk);
    media_rdy = 0; err_unc = 0; err_wr = 0; status_rd = 0;
  endtask

  task automatic stat_read();
    @(negedge clk);
    status_rd = 1;
    @(negedge clk);
    status_rd = 0;
  endtask

  task automatic words(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      dat_valid = 1;
    end
    @(negedge clk);
    dat_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_st("R1 reset", 0, 0, 0, 0, 0, 0);

    // R2 single-sector read, two sectors
    issue(8'h20, 2, 0);
    expect_st("R2 rd busy", 1, 0, 0, 0, 0, 2);
    media(0, 0, 0);
    expect_st("R2 rd drq+irq", 0, 1, 1, 0, 0, 2);
    stat_read();
    expect_st("R9 status read clears", 0, 1, 0, 0, 0, 2);
    words(WORDS);
    expect_st("R2 rd next busy", 1, 0, 0, 0, 0, 1);
    media(0, 0, 0);
    words(WORDS);
    expect_st("R2 rd done", 0, 0, 1, 0, 0, 0);

    // R3 single-sector write, two sectors
    issue(8'h30, 2, 0);
    expect_st("R3 wr first drq no irq", 0, 1, 0, 0, 0, 2);
    words(WORDS);
    expect_st("R3 wr busy", 1, 0, 0, 0, 0, 2);
    media(0, 0, 0);
    expect_st("R3 wr next drq+irq", 0, 1, 1, 0, 0, 1);
    words(WORDS);
    media(0, 0, 0);
    expect_st("R3 wr done", 0, 0, 1, 0, 0, 0);

    // R5 multiple with no block size, and unknown code
    issue(8'hC4, 3, 0);
    expect_st("R5 no block size", 0, 0, 1, 1, 1, 3);
    issue(8'h55, 1, 4);
    expect_st("R5 unknown code", 0, 0, 1, 1, 1, 1);

    // R4 read multiple, block 4, count 6
    issue(8'hC4, 6, 4);
    expect_st("R4 rdm busy", 1, 0, 0, 0, 0, 6);
    media(0, 0, 0);
    expect_st("R4 rdm block start", 0, 1, 1, 0, 0, 6);
    stat_read();
    words(WORDS);
    expect_st("R4 no irq mid block", 0, 1, 0, 0, 0, 6);
    words(3 * WORDS);
    expect_st("R4 block end", 1, 0, 0, 0, 0, 2);
    media(0, 0, 0);
    expect_st("R4 partial block start", 0, 1, 1, 0, 0, 2);
    words(2 * WORDS);
    expect_st("R4 partial block done", 0, 0, 1, 0, 0, 0);

    // R6 uncorrectable read error
    issue(8'hC4, 4, 2);
    media(1, 0, 0);
    expect_st("R6 err block still drq", 0, 1, 1, 1, 0, 4);
    words(2 * WORDS);
    expect_st("R6 stop after block", 0, 0, 1, 1, 0, 2);

    // R7 write error
    issue(8'hC5, 4, 2);
    expect_st("R7 wrm first drq", 0, 1, 0, 0, 0, 4);
    words(2 * WORDS);
    expect_st("R7 wrm busy", 1, 0, 0, 0, 0, 4);
    media(0, 1, 0);
    expect_st("R7 write fault ends", 0, 0, 1, 1, 0, 4);

    // R8 zero count, R10 abandoned by a new command
    issue(8'h20, 0, 0);
    expect_st("R8 zero means 256", 1, 0, 0, 0, 0, 256);
    issue(8'h30, 1, 0);
    expect_st("R10 new cmd restarts", 0, 1, 0, 0, 0, 1);
    words(WORDS);
    media(0, 0, 0);
    expect_st("R10 new cmd completes", 0, 0, 1, 0, 0, 0);

    // R9 set and status read in the same cycle
    issue(8'h20, 1, 0);
    media(0, 0, 1);
    expect_st("R9 set wins over clear", 0, 1, 1, 0, 0, 1);
    words(WORDS);

    // R11 strobes without drq ignored, R12 exact word count
    issue(8'h20, 1, 0);
    words(3);
    expect_st("R11 strobes ignored", 1, 0, 0, 0, 0, 1);
    media(0, 0, 0);
    words(WORDS - 1);
    expect_st("R12 one word short", 0, 1, 1, 0, 0, 1);
    words(1);
    expect_st("R12 sector complete", 0, 0, 1, 0, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule